// File: doc/BRIEF.md
# Boolean Accumulator Instruction Executor

This block runs one bit-logic, load or compare instruction per clock in which the strobe `valid` is high, in the style of a ladder-logic controller CPU. It holds a result bit, an OR helper bit that supports "AND before OR" evaluation, a not-first flag, a status bit, two condition-code bits and two signed word accumulators. An eight-level nesting stack handles parenthesised Boolean sub-expressions. A bit assignment produces a one-cycle write strobe with the result bit as data. The strobe is gated by a master-control enable.

The surrounding sequencer fetches and decodes instructions. It supplies the opcode, the referenced bit value (for an assignment, the target's present value) and the word operand. The executor keeps all processor-visible status on its ports, so a checker or a debug view can follow every instruction. Nesting faults set sticky flags that only reset clears.

Top module: `bitlogic_exec`

## Requirements
- R1: While `rst_n` is low, every register output, the nesting depth, `wr_en`, `wr_data` and both fault flags read zero.
- R2: Opcode 1 (AND) and opcode 2 (AND with inverted operand) use the operand term v (the bit, or its inverse for opcode 2). If `nfc` was 1, the new result is old result AND (v OR `orb`). If `nfc` was 0, the new result is v OR `orb`. `sta` takes the raw operand bit and `nfc` becomes 1.
- R3: Opcode 3 (OR) and opcode 4 (OR with inverted operand) set the result to (`nfc` AND result) OR v. `sta` takes the raw bit, `nfc` becomes 1 and `orb` is kept. Opcode 5 (OR separator) copies the result into `orb` when `nfc` is 1, keeps `orb` otherwise, and clears `nfc`.
- R4: Opcode 6 (load) moves `acc1` into `acc2` and the word operand into `acc1` in the same cycle.
- R5: Opcodes 7..12 compare `acc2` (left) against `acc1` (right) as signed 16-bit values, in this order: equal, not equal, greater, greater-or-equal, less, less-or-equal. The outcome goes to the result bit. `cc0` becomes (`acc1` > `acc2`), `cc1` becomes (`acc1` < `acc2`), `orb` is cleared and `nfc` is set.
- R6: Opcodes 13..16 open a nested level, in the order AND, AND-NOT, OR, OR-NOT. The pushed entry records the opening kind. For the AND kinds the saved result is (result OR NOT `nfc`). For the OR kinds it is (result AND `nfc`). The saved OR bit is (`orb` AND `nfc`). Afterwards `orb` is 0, `sta` is 1, `nfc` is 0 and the depth has risen by one.
- R7: Opcode 17 closes a level. The inner result is inverted for the negated kinds. For the AND kinds the result becomes saved AND (inner OR saved OR bit). For the OR kinds it becomes saved OR inner OR saved OR bit. `orb` is restored from the saved OR bit, `nfc` is set and the depth falls by one.
- R8: Opcode 18 (assign) with `mcr_en` high pulses `wr_en` for one cycle with `wr_data` equal to the result bit. With `mcr_en` low there is no pulse. In both cases `sta` takes the target's resulting value, and `orb` and `nfc` are cleared.
- R9: An open at depth 8 sets the sticky flag `nest_ovf`. A close at depth 0 sets the sticky flag `nest_unf`. In both cases every other output is left unchanged.
- R10: With `valid` low, or with an unassigned opcode (0 or 19..31), no register changes. Every instruction takes effect at the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid | input | 1 | Instruction strobe |
| opcode | input | 5 | Instruction code |
| op_bit | input | 1 | Referenced bit value, or present value of the assignment target |
| op_word | input | 16 | Word operand for load |
| mcr_en | input | 1 | Master-control enable for assignments |
| rlo | output | 1 | Result bit |
| orb | output | 1 | OR helper bit |
| nfc | output | 1 | Not-first flag |
| sta | output | 1 | Status bit |
| cc0 | output | 1 | Condition code 0 |
| cc1 | output | 1 | Condition code 1 |
| acc1 | output | 16 | Accumulator 1 |
| acc2 | output | 16 | Accumulator 2 |
| depth | output | 4 | Nesting levels in use |
| wr_en | output | 1 | Assignment write strobe |
| wr_data | output | 1 | Assignment write value |
| nest_ovf | output | 1 | Sticky nesting overflow |
| nest_unf | output | 1 | Sticky nesting underflow |

## Verification
The bench targets four kinds of fault:
- **Not-first flag ignored in an AND.** An AND right after an assignment or a parenthesis open must start fresh. A design that merged it would keep a stale zero in the result.
- **Signed compare with wrong operand order.** Compares run on negative and equal operands. A design that swapped the operands or compared unsigned would flip the result bit and swap `cc0` with `cc1`.
- **Stack overflow and underflow.** The bench fills all eight levels, pushes a ninth, then drains past empty. A stack that wrapped or lost an entry would return wrong saved values, or would change registers on the faulting instruction.
- **Assignment gating.** Assignments with the master enable low must emit no strobe while `sta` still follows the target's value.

// File: rtl/bitlogic_pkg.sv
`timescale 1ns/1ps
package bitlogic_pkg;

  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_AND     = 5'd1,
    OP_ANDN    = 5'd2,
    OP_OR      = 5'd3,
    OP_ORN     = 5'd4,
    OP_ORSEP   = 5'd5,
    OP_LOAD    = 5'd6,
    OP_EQ      = 5'd7,
    OP_NE      = 5'd8,
    OP_GT      = 5'd9,
    OP_GE      = 5'd10,
    OP_LT      = 5'd11,
    OP_LE      = 5'd12,
    OP_OPEN_A  = 5'd13,
    OP_OPEN_AN = 5'd14,
    OP_OPEN_O  = 5'd15,
    OP_OPEN_ON = 5'd16,
    OP_CLOSE   = 5'd17,
    OP_ASSIGN  = 5'd18
  } opcode_e;

  // kind of nested level, kept on the stack
  typedef enum logic [2:0] {
    FC_AND  = 3'd0,
    FC_ANDN = 3'd1,
    FC_OR   = 3'd2,
    FC_ORN  = 3'd3
  } nest_fc_e;

  typedef struct packed {
    nest_fc_e fc;
    logic     s_or;
    logic     s_rlo;
  } nest_ent_t;

endpackage

// File: rtl/bitlogic_rst_sync.sv
`timescale 1ns/1ps
module bitlogic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bitlogic_cmp.sv
`timescale 1ns/1ps
module bitlogic_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  output logic         a1_gt,
  output logic         a1_lt
);

  assign a1_gt = $signed(a1) > $signed(a2);
  assign a1_lt = $signed(a1) < $signed(a2);

endmodule

// File: rtl/bitlogic_stack.sv
`timescale 1ns/1ps
module bitlogic_stack
  import bitlogic_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  nest_ent_t     push_ent,
  output nest_ent_t     top_ent,
  output logic [DW-1:0] depth,
  output logic          full,
  output logic          empty
);

  nest_ent_t     ent_q [DEPTH];
  logic [DW-1:0] depth_q, depth_d;

  // entry 0 is the top; a push moves all entries one level deeper
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    nest_ent_t ent_d;
    if (i == 0) begin : g_top
      always_comb begin
        ent_d = ent_q[i];
        if (push)     ent_d = push_ent;
        else if (pop) ent_d = (DEPTH > 1) ? ent_q[(DEPTH > 1) ? 1 : 0] : '0;
      end
    end else if (i == DEPTH - 1) begin : g_bot
      always_comb begin
        ent_d = ent_q[i];
        if (push)     ent_d = ent_q[i-1];
        else if (pop) ent_d = '0;
      end
    end else begin : g_mid
      always_comb begin
        ent_d = ent_q[i];
        if (push)     ent_d = ent_q[i-1];
        else if (pop) ent_d = ent_q[i+1];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ent_q[i] <= '0;
      else if (push | pop) ent_q[i] <= ent_d;
    end
  end

  always_comb begin
    depth_d = depth_q;
    if (push)     depth_d = depth_q + DW'(1);
    else if (pop) depth_d = depth_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          depth_q <= '0;
    else if (push | pop) depth_q <= depth_d;
  end

  assign top_ent = ent_q[0];
  assign depth   = depth_q;
  assign full    = (depth_q == DW'(DEPTH));
  assign empty   = (depth_q == '0);

endmodule

// File: rtl/bitlogic_exec.sv
`timescale 1ns/1ps
module bitlogic_exec
  import bitlogic_pkg::*;
#(
  parameter int W          = 16,
  parameter int NEST_DEPTH = 8,
  localparam int DW = $clog2(NEST_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [4:0]    opcode,
  input  logic          op_bit,
  input  logic [W-1:0]  op_word,
  input  logic          mcr_en,
  output logic          rlo,
  output logic          orb,
  output logic          nfc,
  output logic          sta,
  output logic          cc0,
  output logic          cc1,
  output logic [W-1:0]  acc1,
  output logic [W-1:0]  acc2,
  output logic [DW-1:0] depth,
  output logic          wr_en,
  output logic          wr_data,
  output logic          nest_ovf,
  output logic          nest_unf
);

  logic      rst_sync_n;
  opcode_e   op;
  logic      a1_gt, a1_lt;
  logic      push, pop, full, empty;
  nest_ent_t push_ent, top_ent;

  logic         rlo_q, orb_q, nfc_q, sta_q, cc0_q, cc1_q;
  logic         rlo_d, orb_d, nfc_d, sta_d, cc0_d, cc1_d;
  logic [W-1:0] acc1_q, acc2_q, acc1_d, acc2_d;
  logic         wr_en_q, wr_en_d, wr_data_q, wr_data_d;
  logic         ovf_q, ovf_d, unf_q, unf_d;
  logic         reg_en;

  // helpers for the decode
  logic v_term, inner, top_or_kind, top_neg_kind, is_cmp;

  assign op = opcode_e'(opcode);

  bitlogic_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitlogic_cmp #(.W(W)) u_cmp (
    .a1    (acc1_q),
    .a2    (acc2_q),
    .a1_gt (a1_gt),
    .a1_lt (a1_lt)
  );

  bitlogic_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (push),
    .pop      (pop),
    .push_ent (push_ent),
    .top_ent  (top_ent),
    .depth    (depth),
    .full     (full),
    .empty    (empty)
  );

  assign top_or_kind  = (top_ent.fc == FC_OR)   || (top_ent.fc == FC_ORN);
  assign top_neg_kind = (top_ent.fc == FC_ANDN) || (top_ent.fc == FC_ORN);
  assign inner        = top_neg_kind ? ~rlo_q : rlo_q;
  assign v_term       = ((op == OP_ANDN) || (op == OP_ORN)) ? ~op_bit : op_bit;
  assign is_cmp       = (op == OP_EQ) || (op == OP_NE) || (op == OP_GT) ||
                        (op == OP_GE) || (op == OP_LT) || (op == OP_LE);

  // next-state decode
  always_comb begin
    rlo_d     = rlo_q;
    orb_d     = orb_q;
    nfc_d     = nfc_q;
    sta_d     = sta_q;
    cc0_d     = cc0_q;
    cc1_d     = cc1_q;
    acc1_d    = acc1_q;
    acc2_d    = acc2_q;
    wr_en_d   = 1'b0;
    wr_data_d = wr_data_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    push      = 1'b0;
    pop       = 1'b0;
    push_ent  = '0;

    if (valid) begin
      if (is_cmp) begin
        unique case (op)
          OP_EQ:   rlo_d = ~a1_gt & ~a1_lt;
          OP_NE:   rlo_d = a1_gt | a1_lt;
          OP_GT:   rlo_d = a1_lt;
          OP_GE:   rlo_d = ~a1_gt;
          OP_LT:   rlo_d = a1_gt;
          default: rlo_d = ~a1_lt;
        endcase
        cc0_d = a1_gt;
        cc1_d = a1_lt;
        orb_d = 1'b0;
        nfc_d = 1'b1;
      end else begin
        case (op)
          OP_AND, OP_ANDN: begin
            rlo_d = nfc_q ? (rlo_q & (v_term | orb_q)) : (v_term | orb_q);
            sta_d = op_bit;
            nfc_d = 1'b1;
          end
          OP_OR, OP_ORN: begin
            rlo_d = (nfc_q & rlo_q) | v_term;
            sta_d = op_bit;
            nfc_d = 1'b1;
          end
          OP_ORSEP: begin
            if (nfc_q) orb_d = rlo_q;
            nfc_d = 1'b0;
          end
          OP_LOAD: begin
            acc2_d = acc1_q;
            acc1_d = op_word;
          end
          OP_OPEN_A, OP_OPEN_AN, OP_OPEN_O, OP_OPEN_ON: begin
            if (full) begin
              ovf_d = 1'b1;
            end else begin
              push = 1'b1;
              unique case (op)
                OP_OPEN_A:  push_ent.fc = FC_AND;
                OP_OPEN_AN: push_ent.fc = FC_ANDN;
                OP_OPEN_O:  push_ent.fc = FC_OR;
                default:    push_ent.fc = FC_ORN;
              endcase
              if ((op == OP_OPEN_A) || (op == OP_OPEN_AN))
                push_ent.s_rlo = rlo_q | ~nfc_q;
              else
                push_ent.s_rlo = rlo_q & nfc_q;
              push_ent.s_or = orb_q & nfc_q;
              orb_d = 1'b0;
              sta_d = 1'b1;
              nfc_d = 1'b0;
            end
          end
          OP_CLOSE: begin
            if (empty) begin
              unf_d = 1'b1;
            end else begin
              pop = 1'b1;
              if (top_or_kind)
                rlo_d = top_ent.s_rlo | inner | top_ent.s_or;
              else
                rlo_d = top_ent.s_rlo & (inner | top_ent.s_or);
              orb_d = top_ent.s_or;
              nfc_d = 1'b1;
            end
          end
          OP_ASSIGN: begin
            if (mcr_en) begin
              wr_en_d   = 1'b1;
              wr_data_d = rlo_q;
            end
            sta_d = mcr_en ? rlo_q : op_bit;
            orb_d = 1'b0;
            nfc_d = 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_en = valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rlo_q     <= 1'b0;
      orb_q     <= 1'b0;
      nfc_q     <= 1'b0;
      sta_q     <= 1'b0;
      cc0_q     <= 1'b0;
      cc1_q     <= 1'b0;
      acc1_q    <= '0;
      acc2_q    <= '0;
      wr_data_q <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else if (reg_en) begin
      rlo_q     <= rlo_d;
      orb_q     <= orb_d;
      nfc_q     <= nfc_d;
      sta_q     <= sta_d;
      cc0_q     <= cc0_d;
      cc1_q     <= cc1_d;
      acc1_q    <= acc1_d;
      acc2_q    <= acc2_d;
      wr_data_q <= wr_data_d;
      ovf_q     <= ovf_d;
      unf_q     <= unf_d;
    end
  end

  // strobe register runs every cycle so the pulse ends by itself
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_en_q <= 1'b0;
    else             wr_en_q <= wr_en_d;
  end

  assign rlo      = rlo_q;
  assign orb      = orb_q;
  assign nfc      = nfc_q;
  assign sta      = sta_q;
  assign cc0      = cc0_q;
  assign cc1      = cc1_q;
  assign acc1     = acc1_q;
  assign acc2     = acc2_q;
  assign wr_en    = wr_en_q;
  assign wr_data  = wr_data_q;
  assign nest_ovf = ovf_q;
  assign nest_unf = unf_q;

endmodule

// File: rtl/bitlogic_exec_chk.sv
`timescale 1ns/1ps
module bitlogic_exec_chk
  import bitlogic_pkg::*;
#(
  parameter int W          = 16,
  parameter int NEST_DEPTH = 8,
  localparam int DW = $clog2(NEST_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid,
  input logic [4:0]    opcode,
  input logic          mcr_en,
  input logic [W-1:0]  op_word,
  input logic          rlo,
  input logic          orb,
  input logic          nfc,
  input logic          sta,
  input logic          cc0,
  input logic [W-1:0]  acc1,
  input logic [W-1:0]  acc2,
  input logic [DW-1:0] depth,
  input logic          wr_en,
  input logic          nest_ovf,
  input logic          nest_unf
);

  logic is_open, is_cmp_op;
  assign is_open   = (opcode >= 5'(OP_OPEN_A)) && (opcode <= 5'(OP_OPEN_ON));
  assign is_cmp_op = (opcode >= 5'(OP_EQ)) && (opcode <= 5'(OP_LE));

  // R8: a write strobe only follows an enabled assignment
  p_strobe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(valid && (opcode == 5'(OP_ASSIGN)) && mcr_en));

  // R4: load shifts the accumulators
  p_load_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && opcode == 5'(OP_LOAD)) |=> (acc2 == $past(acc1)) && (acc1 == $past(op_word)));

  // R5: compares leave helper bits in a known state
  p_cmp_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_cmp_op) |=> nfc && !orb);

  // R6: a legal open pushes and restarts the expression
  p_open_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_open && depth < DW'(NEST_DEPTH)) |=>
      (depth == $past(depth) + DW'(1)) && sta && !nfc && !orb);

  // R7: a legal close pops and marks the result as computed
  p_close_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && opcode == 5'(OP_CLOSE) && depth != '0) |=>
      (depth == $past(depth) - DW'(1)) && nfc);

  // R9: faults are sticky and never disturb the depth
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nest_ovf |=> nest_ovf);
  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nest_unf |=> nest_unf);
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NEST_DEPTH));
  p_underflow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && opcode == 5'(OP_CLOSE) && depth == '0) |=>
      nest_unf && (depth == '0) && $stable(rlo) && $stable(nfc));

  // R10: idle cycles change nothing
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(rlo) && $stable(sta) && $stable(cc0) && $stable(acc1) && $stable(depth) && !wr_en);

endmodule

bind bitlogic_exec bitlogic_exec_chk #(.W(W), .NEST_DEPTH(NEST_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid    (valid),
  .opcode   (opcode),
  .mcr_en   (mcr_en),
  .op_word  (op_word),
  .rlo      (rlo),
  .orb      (orb),
  .nfc      (nfc),
  .sta      (sta),
  .cc0      (cc0),
  .acc1     (acc1),
  .acc2     (acc2),
  .depth    (depth),
  .wr_en    (wr_en),
  .nest_ovf (nest_ovf),
  .nest_unf (nest_unf)
);

// File: tb/bitlogic_exec_tb.sv
`timescale 1ns/1ps
module bitlogic_exec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic        op_bit = 1'b0;
  logic [15:0] op_word = '0;
  logic        mcr_en = 1'b0;
  logic        rlo, orb, nfc, sta, cc0, cc1, wr_en, wr_data, nest_ovf, nest_unf;
  logic [15:0] acc1, acc2;
  logic [3:0]  depth;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bitlogic_exec u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .op_bit(op_bit),
    .op_word(op_word), .mcr_en(mcr_en), .rlo(rlo), .orb(orb), .nfc(nfc), .sta(sta),
    .cc0(cc0), .cc1(cc1), .acc1(acc1), .acc2(acc2), .depth(depth), .wr_en(wr_en),
    .wr_data(wr_data), .nest_ovf(nest_ovf), .nest_unf(nest_unf)
  );

  // behavioural reference state
  bit      m_rlo, m_orb, m_nfc, m_sta, m_cc0, m_cc1, m_wr, m_wd, m_ovf, m_unf;
  shortint m_a1, m_a2;
  bit [4:0] m_stk[$];   // {kind[2:0], saved_or, saved_rlo}, front is top

  task automatic model_reset();
    {m_rlo, m_orb, m_nfc, m_sta, m_cc0, m_cc1, m_wr, m_wd, m_ovf, m_unf} = '0;
    m_a1 = 0; m_a2 = 0;
    m_stk.delete();
  endtask

  task automatic model_step(input bit v, input int op, input bit b, input logic [15:0] w, input bit m);
    bit t, inr;
    bit [4:0] e;
    m_wr = 0;
    if (!v) return;
    case (op)
      1, 2: begin
        t = (op == 2) ? !b : b;
        m_rlo = m_nfc ? (m_rlo && (t || m_orb)) : (t || m_orb);
        m_sta = b; m_nfc = 1;
      end
      3, 4: begin
        t = (op == 4) ? !b : b;
        m_rlo = (m_nfc && m_rlo) || t;
        m_sta = b; m_nfc = 1;
      end
      5: begin
        if (m_nfc) m_orb = m_rlo;
        m_nfc = 0;
      end
      6: begin m_a2 = m_a1; m_a1 = shortint'(w); end
      7, 8, 9, 10, 11, 12: begin
        case (op)
          7: m_rlo = (m_a2 == m_a1);
          8: m_rlo = (m_a2 != m_a1);
          9: m_rlo = (m_a2 > m_a1);
          10: m_rlo = (m_a2 >= m_a1);
          11: m_rlo = (m_a2 < m_a1);
          default: m_rlo = (m_a2 <= m_a1);
        endcase
        m_cc0 = (m_a1 > m_a2); m_cc1 = (m_a1 < m_a2);
        m_orb = 0; m_nfc = 1;
      end
      13, 14, 15, 16: begin
        if (m_stk.size() == 8) m_ovf = 1;
        else begin
          e[4:2] = 3'(op - 13);
          e[1] = m_orb && m_nfc;
          e[0] = (op <= 14) ? (m_rlo || !m_nfc) : (m_rlo && m_nfc);
          m_stk.push_front(e);
          m_orb = 0; m_sta = 1; m_nfc = 0;
        end
      end
      17: begin
        if (m_stk.size() == 0) m_unf = 1;
        else begin
          e = m_stk.pop_front();
          inr = (e[4:2] == 1 || e[4:2] == 3) ? !m_rlo : m_rlo;
          if (e[4:2] >= 2) m_rlo = e[0] || inr || e[1];
          else             m_rlo = e[0] && (inr || e[1]);
          m_orb = e[1]; m_nfc = 1;
        end
      end
      18: begin
        if (m) begin m_wr = 1; m_wd = m_rlo; end
        m_sta = m ? m_rlo : b;
        m_orb = 0; m_nfc = 0;
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input bit v, input int op);
    if (!v || op == 0 || op > 18) return "R10";
    if (op <= 2)  return "R2";
    if (op <= 5)  return "R3";
    if (op == 6)  return "R4";
    if (op <= 12) return "R5";
    if (op <= 16) return (m_stk.size() == 8) ? "R9" : "R6";
    if (op == 17) return (m_stk.size() == 0) ? "R9" : "R7";
    return "R8";
  endfunction

  task automatic compare(input string tag);
    logic [55:0] act, exp;
    act = {rlo, orb, nfc, sta, cc0, cc1, acc1, acc2, depth, wr_en, wr_data, nest_ovf, nest_unf};
    exp = {m_rlo, m_orb, m_nfc, m_sta, m_cc0, m_cc1, m_a1, m_a2, 4'(m_stk.size()), m_wr, m_wd, m_ovf, m_unf};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // present at a falling edge, take effect at the next rising edge, compare at the falling edge after
  task automatic step(input bit v, input int op, input bit b = 0, input logic [15:0] w = '0, input bit m = 1);
    string tag;
    tag = tag_of(v, op);
    valid = v; opcode = 5'(op); op_bit = b; op_word = w; mcr_en = m;
    model_step(v, op, b, w, m);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    valid = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    compare("R1");
    @(negedge clk);
    compare("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R1");
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();

    // R2 first AND starts fresh, later ANDs merge
    step(1, 1, 1); step(1, 1, 1); step(1, 2, 1); step(1, 1, 1);
    // R8 assign clears not-first, next AND starts fresh
    step(1, 18, 0, 0, 1); step(1, 1, 1);
    // R3 and-before-or chain: a&b | c
    step(1, 18, 0, 0, 1);
    step(1, 1, 1); step(1, 1, 0); step(1, 5); step(1, 1, 1); step(1, 4, 1); step(1, 3, 0);
    step(1, 5); step(1, 5);
    // R4 / R5 signed compares, equal and negative operands
    step(1, 6, 0, 16'hFFFE); step(1, 6, 0, 16'h0003);
    for (int c = 7; c <= 12; c++) step(1, c);
    step(1, 6, 0, 16'h0003);
    for (int c = 7; c <= 12; c++) step(1, c);
    step(1, 6, 0, 16'h8000);
    for (int c = 7; c <= 12; c++) step(1, c);
    // R8 gated assignment: no strobe, status follows target
    step(1, 18, 1, 0, 0); step(1, 18, 0, 0, 0); step(1, 18, 1, 0, 1);
    // R6 / R7 each opening kind
    for (int k = 13; k <= 16; k++) begin
      step(1, 1, 1); step(1, k); step(1, 1, 0); step(1, 3, 1); step(1, 17);
      step(1, 2, 1); step(1, k); step(1, 1, 0); step(1, 17);
    end
    // R9 fill eight levels, overflow, drain, underflow
    step(1, 18, 0, 0, 1);
    for (int d = 0; d < 8; d++) begin step(1, 13 + (d % 4)); step(1, 1, d[0]); end
    step(1, 13); step(1, 15);
    for (int d = 0; d < 8; d++) step(1, 17);
    step(1, 17); step(1, 17);
    // R10 idle and unassigned codes
    step(0, 6, 1, 16'h1234); step(1, 0, 1); step(1, 25, 1, 16'h5555);
    // R1 reset clears sticky faults
    do_reset();
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      automatic int op = $urandom_range(0, 19);
      automatic logic [15:0] w = 16'($signed($urandom_range(0, 6)) - 3);
      step($urandom_range(0, 9) != 0, op, 1'($urandom_range(0, 1)), w, $urandom_range(0, 3) != 0);
      if (n == 300) do_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule